// File: doc/BRIEF.md
# Multi-Queue Shared-Memory Queue Manager

This block keeps a set of hardware FIFO queues in one shared word RAM and exposes them to a bus master through a simple request/response register port. Each queue owns a 128-word ring in the RAM. Its word pointers, its entry size (1, 2 or 4 words) and its depth in entries (a power of two) are held in one configuration word per queue. The master pushes an entry by writing the queue's access window and pops one by reading it. Multi-word entries use consecutive word offsets, and the pointer moves only on the last word of an entry.

Because the pointers are 7-bit word pointers that wrap at 128, equal pointers can mean either empty or full. A per-queue full flag settles this. Queues below `LOW_Q` (the lower group) report empty, nearly-empty, nearly-full and full, and keep sticky underflow and overflow flags. Software clears these flags by writing zeros. Queues at or above `LOW_Q` (the upper group) report only nearly-empty and full, and they never raise flags.

Address map (12-bit word address). Bits [11:10] select the space:
- 0 selects the access window. The queue is in bits [9:2] and the word offset is in bits [1:0].
- 1 selects the configuration word of the queue held in bits [9:0].
- 2 selects the status registers, indexed by bits [1:0], with bits [9:2] zero.
- 3 is unused.

A request whose queue number lies outside the queue count, or that sets address bits above it, has no effect.

Top module: `qm_top`

## Requirements
- R1: After reset every configuration word reads 0x0004_0000 (pointers 0, entry size code 0, size code 4 = 16 entries, full 0), and every sticky flag is clear.
- R2: Every read request produces `rsp_valid` high, with its data, exactly one cycle after the request cycle. A write request leaves `rsp_valid` low in that cycle.
- R3: Single-word entries pushed to a queue pop back in the same order and with the same values.
- R4: An entry of N words (size code 0/1/2 = 1/2/4 words, code 3 acting as 4) is pushed or popped at offsets 0..N-1. Both pointers advance by N only on offset N-1. An access at an offset of N or more is ignored, and a read there returns 0.
- R5: The configuration word holds the write pointer in [6:0], the read pointer in [13:7], the entry size code in [15:14], the log2 size in [18:16] and a read-only full flag in [19]. Writing it loads all of these and clears the full flag. Pointers wrap modulo 128.
- R6: The entry count is ((wp − rp) mod 128 / N) masked to the queue size, except that a set full flag forces the count to the queue size. A queue whose ring is exactly 128 words therefore reports full while its pointers are equal.
- R7: Popping an empty lower-group queue returns 0, moves no pointer, and sets underflow bit q of status register 0.
- R8: Pushing to a full lower-group queue stores nothing, moves no pointer, and sets overflow bit 16+q of status register 0.
- R9: Writing status register 0 clears each sticky flag whose bit is written 0 and leaves the flags written 1 unchanged.
- R10: Status register 1 gives each lower-group queue q a nibble at bits [4q+3:4q] ordered {full, nearly-full, nearly-empty, empty}. Nearly-empty is count ≤ 1 and nearly-full is size − count ≤ 1.
- R11: Status registers 2 and 3 hold, at bit q − LOW_Q, the nearly-empty and the full state of each upper-group queue. Upper-group underflow and overflow are silent: the read returns 0, the write is dropped, and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
Every result of this block appears one cycle after its request. Read data and `rsp_valid` come back in that cycle. Pointer, full-flag and sticky-flag updates are visible to any request issued in the following cycle. The bench drives each request at a falling edge and samples the response at the next falling edge, so it checks every read exactly one register stage later. Its behavioural queue model updates at the moment each request is issued, so each later read of configuration or status is compared against the state that includes all earlier accesses.

// File: rtl/qm_pkg.sv
package qm_pkg;
    localparam int PTR_W      = 7;
    localparam int RING_WORDS = 128;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int OF_BASE    = 16;

    typedef enum logic [1:0] {
        SP_ACCESS = 2'd0,
        SP_CONFIG = 2'd1,
        SP_STATUS = 2'd2,
        SP_NONE   = 2'd3
    } space_e;

    localparam logic [2:0] LGSZ_RESET = 3'd4;

    // words per entry as a shift amount: code 0 -> 1, 1 -> 2, 2/3 -> 4
    function automatic logic [1:0] es_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/qm_qstat.sv
module qm_qstat
    import qm_pkg::*;
(
    input  logic [PTR_W-1:0] wp,
    input  logic [PTR_W-1:0] rp,
    input  logic [1:0]       es_code,
    input  logic [2:0]       lgsz,
    input  logic             full_flag,
    output logic [PTR_W:0]   count,
    output logic             empty,
    output logic             near_empty,
    output logic             near_full,
    output logic             full
);
    logic [PTR_W-1:0] occ;
    logic [PTR_W-1:0] ent;
    logic [PTR_W:0]   size;

    always_comb begin
        occ        = wp - rp;
        ent        = occ >> es_shift(es_code);
        size       = (PTR_W+1)'(1) << lgsz;
        count      = full_flag ? size : ({1'b0, ent} & (size - (PTR_W+1)'(1)));
        full       = full_flag;
        empty      = !full_flag && (count == '0);
        near_empty = count <= (PTR_W+1)'(1);
        near_full  = (size - count) <= (PTR_W+1)'(1);
    end
endmodule

// File: rtl/qm_word_ram.sv
module qm_word_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/qm_top.sv
module qm_top
    import qm_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int LOW_Q = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int QW        = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int UP_Q      = NUM_Q - LOW_Q;
    localparam int RAM_DEPTH = NUM_Q * RING_WORDS;
    localparam int RAM_AW    = QW + PTR_W;

    typedef struct packed {
        logic [NUM_Q-1:0][PTR_W-1:0] wp;
        logic [NUM_Q-1:0][PTR_W-1:0] rp;
        logic [NUM_Q-1:0][1:0]       es;
        logic [NUM_Q-1:0][2:0]       lgsz;
        logic [NUM_Q-1:0]            full;
        logic [LOW_Q-1:0]            uf;
        logic [LOW_Q-1:0]            of;
        logic                        rsp_valid;
        logic                        rsp_mem;
        logic [DATA_W-1:0]           rsp_reg;
    } state_t;

    state_t s_q, s_d;

    // per-queue status
    logic [NUM_Q-1:0][PTR_W:0] cnt;
    logic [NUM_Q-1:0] q_empty, q_ne, q_nf, q_full;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_stat
        qm_qstat u_stat (
            .wp        (s_q.wp[g]),
            .rp        (s_q.rp[g]),
            .es_code   (s_q.es[g]),
            .lgsz      (s_q.lgsz[g]),
            .full_flag (s_q.full[g]),
            .count     (cnt[g]),
            .empty     (q_empty[g]),
            .near_empty(q_ne[g]),
            .near_full (q_nf[g]),
            .full      (q_full[g])
        );
    end

    // request decode
    space_e          space;
    logic [QW-1:0]   qsel;
    logic [1:0]      woff;
    logic            q_ok, is_lower, acc_hit, cfg_hit, st_hit;
    logic [2:0]      words;
    logic            last_word;
    logic            push_ok, push_blocked, pop_ok, pop_empty;
    logic [PTR_W:0]  size_sel;

    always_comb begin
        space     = space_e'(req_addr[11:10]);
        qsel      = (space == SP_ACCESS) ? req_addr[2 +: QW] : req_addr[QW-1:0];
        woff      = req_addr[1:0];
        q_ok      = {1'b0, qsel} < (QW+1)'(NUM_Q);
        is_lower  = {1'b0, qsel} < (QW+1)'(LOW_Q);
        acc_hit   = req_valid && (space == SP_ACCESS) && q_ok
                    && ((req_addr[9:2] >> QW) == '0);
        cfg_hit   = req_valid && (space == SP_CONFIG) && q_ok
                    && ((req_addr[9:0] >> QW) == '0);
        st_hit    = req_valid && (space == SP_STATUS) && (req_addr[9:2] == '0);
        words     = 3'd1 << es_shift(s_q.es[qsel]);
        last_word = {1'b0, woff} == (words - 3'd1);
        size_sel  = (PTR_W+1)'(1) << s_q.lgsz[qsel];
        acc_hit   = acc_hit && ({1'b0, woff} < words);
        push_ok      = acc_hit && req_write && !q_full[qsel];
        push_blocked = acc_hit && req_write && q_full[qsel];
        pop_ok       = acc_hit && !req_write && !q_empty[qsel];
        pop_empty    = acc_hit && !req_write && q_empty[qsel];
    end

    // RAM
    logic              ram_we, ram_re;
    logic [RAM_AW-1:0] ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_rdata;

    assign ram_we    = push_ok;
    assign ram_re    = pop_ok;
    assign ram_waddr = {qsel, s_q.wp[qsel] + PTR_W'(woff)};
    assign ram_raddr = {qsel, s_q.rp[qsel] + PTR_W'(woff)};

    qm_word_ram #(
        .DEPTH(RAM_DEPTH),
        .AW   (RAM_AW),
        .DW   (DATA_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(req_wdata),
        .re   (ram_re),
        .raddr(ram_raddr),
        .rdata(ram_rdata)
    );

    // next state
    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid && !req_write;
        s_d.rsp_mem   = 1'b0;
        s_d.rsp_reg   = '0;

        if (push_ok && last_word) begin
            s_d.wp[qsel]   = s_q.wp[qsel] + PTR_W'(words);
            s_d.full[qsel] = (cnt[qsel] + (PTR_W+1)'(1)) == size_sel;
        end
        if (pop_ok) begin
            s_d.rsp_mem = 1'b1;
            if (last_word) begin
                s_d.rp[qsel]   = s_q.rp[qsel] + PTR_W'(words);
                s_d.full[qsel] = 1'b0;
            end
        end
        for (int i = 0; i < LOW_Q; i++) begin
            if (is_lower && (qsel == QW'(i))) begin
                if (pop_empty)    s_d.uf[i] = 1'b1;
                if (push_blocked) s_d.of[i] = 1'b1;
            end
        end

        if (cfg_hit) begin
            if (req_write) begin
                s_d.wp[qsel]   = req_wdata[6:0];
                s_d.rp[qsel]   = req_wdata[13:7];
                s_d.es[qsel]   = req_wdata[15:14];
                s_d.lgsz[qsel] = req_wdata[18:16];
                s_d.full[qsel] = 1'b0;
            end else begin
                s_d.rsp_reg[6:0]   = s_q.wp[qsel];
                s_d.rsp_reg[13:7]  = s_q.rp[qsel];
                s_d.rsp_reg[15:14] = s_q.es[qsel];
                s_d.rsp_reg[18:16] = s_q.lgsz[qsel];
                s_d.rsp_reg[19]    = s_q.full[qsel];
            end
        end

        if (st_hit) begin
            if (req_write) begin
                if (req_addr[1:0] == 2'd0) begin
                    s_d.uf = s_q.uf & req_wdata[LOW_Q-1:0];
                    s_d.of = s_q.of & req_wdata[OF_BASE +: LOW_Q];
                end
            end else begin
                case (req_addr[1:0])
                    2'd0: begin
                        s_d.rsp_reg[LOW_Q-1:0]        = s_q.uf;
                        s_d.rsp_reg[OF_BASE +: LOW_Q] = s_q.of;
                    end
                    2'd1: begin
                        for (int i = 0; i < LOW_Q; i++)
                            s_d.rsp_reg[4*i +: 4] = {q_full[i], q_nf[i], q_ne[i], q_empty[i]};
                    end
                    2'd2: begin
                        for (int i = 0; i < UP_Q; i++)
                            s_d.rsp_reg[i] = q_ne[LOW_Q+i];
                    end
                    default: begin
                        for (int i = 0; i < UP_Q; i++)
                            s_d.rsp_reg[i] = q_full[LOW_Q+i];
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < NUM_Q; i++) s_q.lgsz[i] <= LGSZ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_rdata = s_q.rsp_mem ? ram_rdata : s_q.rsp_reg;

    // assertions
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    p_partial_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !last_word && !cfg_hit) |=> $stable(s_q.wp));
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |=> (rsp_rdata == '0));
    p_uf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_empty && is_lower) |=> (s_q.uf != '0));
    p_blocked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_blocked |=> $stable(s_q.wp));
    p_upper_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_empty || push_blocked) && !is_lower) |=> ($stable(s_q.uf) && $stable(s_q.of)));
endmodule

// File: tb/qm_top_tb.sv
`timescale 1ns/1ps
module qm_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qm_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // behavioural model: 8 queues, 4 lower
    int          m_wp[8], m_rp[8], m_es[8], m_lg[8], m_cnt[8];
    logic [31:0] m_mem[8][128];
    bit          m_uf[4], m_of[4];

    function automatic int esw(int q);
        return (m_es[q] == 0) ? 1 : (m_es[q] == 1) ? 2 : 4;
    endfunction
    function automatic int szq(int q);
        return 1 << m_lg[q];
    endfunction
    function automatic logic [11:0] acc_a(int q, int w);
        return 12'((q << 2) | w);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'b0, rsp_valid}, {31'b0, !wr});
        rd = rsp_rdata;
    endtask

    task automatic push_w(int q, int w, logic [31:0] d);
        logic [31:0] rd;
        if (w < esw(q)) begin
            if (m_cnt[q] == szq(q)) begin
                if (q < 4) m_of[q] = 1;
            end else begin
                m_mem[q][(m_wp[q] + w) % 128] = d;
                if (w == esw(q) - 1) begin
                    m_wp[q] = (m_wp[q] + esw(q)) % 128;
                    m_cnt[q]++;
                end
            end
        end
        xact(1'b1, acc_a(q, w), d, rd);
    endtask

    task automatic pop_w(int q, int w, string tag);
        logic [31:0] rd, exp;
        exp = '0;
        if (w < esw(q)) begin
            if (m_cnt[q] == 0) begin
                if (q < 4) m_uf[q] = 1;
            end else begin
                exp = m_mem[q][(m_rp[q] + w) % 128];
                if (w == esw(q) - 1) begin
                    m_rp[q] = (m_rp[q] + esw(q)) % 128;
                    m_cnt[q]--;
                end
            end
        end
        xact(1'b0, acc_a(q, w), '0, rd);
        check(tag, rd, exp);
    endtask

    task automatic push_e(int q, logic [31:0] base);
        for (int w = 0; w < esw(q); w++) push_w(q, w, base + 32'(w));
    endtask
    task automatic pop_e(int q, string tag);
        for (int w = 0; w < esw(q); w++) pop_w(q, w, tag);
    endtask

    task automatic wr_cfg(int q, int lg, int es, int ptr);
        logic [31:0] rd;
        m_lg[q] = lg; m_es[q] = es; m_wp[q] = ptr; m_rp[q] = ptr; m_cnt[q] = 0;
        xact(1'b1, 12'h400 | 12'(q), 32'((lg << 16) | (es << 14) | (ptr << 7) | ptr), rd);
    endtask

    task automatic rd_cfg(int q, string tag);
        logic [31:0] rd, exp;
        exp = 32'(((m_cnt[q] == szq(q)) << 19) | (m_lg[q] << 16) | (m_es[q] << 14)
                  | (m_rp[q] << 7) | m_wp[q]);
        xact(1'b0, 12'h400 | 12'(q), '0, rd);
        check(tag, rd, exp);
    endtask

    task automatic rd_stat(int idx, string tag);
        logic [31:0] rd, exp;
        exp = '0;
        case (idx)
            0: for (int i = 0; i < 4; i++) begin
                   exp[i] = m_uf[i];
                   exp[16+i] = m_of[i];
               end
            1: for (int i = 0; i < 4; i++)
                   exp[4*i +: 4] = {m_cnt[i] == szq(i), (szq(i) - m_cnt[i]) <= 1,
                                    m_cnt[i] <= 1, m_cnt[i] == 0};
            2: for (int i = 0; i < 4; i++) exp[i] = m_cnt[4+i] <= 1;
            default: for (int i = 0; i < 4; i++) exp[i] = m_cnt[4+i] == szq(4+i);
        endcase
        xact(1'b0, 12'h800 | 12'(idx), '0, rd);
        check(tag, rd, exp);
    endtask

    task automatic wr_stat0(logic [31:0] v);
        logic [31:0] rd;
        for (int i = 0; i < 4; i++) begin
            m_uf[i] = m_uf[i] & v[i];
            m_of[i] = m_of[i] & v[16+i];
        end
        xact(1'b1, 12'h800, v, rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < 8; q++) begin
            m_wp[q] = 0; m_rp[q] = 0; m_es[q] = 0; m_lg[q] = 4; m_cnt[q] = 0;
        end
        for (int i = 0; i < 4; i++) begin m_uf[i] = 0; m_of[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int q = 0; q < 8; q++) rd_cfg(q, "R1 config reset");
        for (int i = 0; i < 4; i++) rd_stat(i, "R1 status reset");

        // R3: FIFO order, single word
        for (int k = 0; k < 5; k++) push_e(0, 32'hA000_0000 + 32'(k * 17));
        rd_cfg(0, "R3 config after push");
        for (int k = 0; k < 5; k++) pop_e(0, "R3 pop order");

        // R4: two-word entries, offset beyond entry ignored
        wr_cfg(1, 3, 1, 0);
        for (int k = 0; k < 3; k++) push_e(1, 32'hB000_0000 + 32'(k * 256));
        push_w(1, 2, 32'hDEAD_BEEF);
        push_w(1, 0, 32'h1234_5678);
        rd_cfg(1, "R4 partial entry keeps wp");
        push_w(1, 1, 32'h9ABC_DEF0);
        rd_cfg(1, "R4 wp after last word");
        pop_w(1, 3, "R4 read beyond entry returns 0");
        for (int k = 0; k < 4; k++) pop_e(1, "R4 two-word pop");
        rd_cfg(1, "R4 rp after pops");

        // R5: pointer wrap
        wr_cfg(2, 4, 0, 120);
        rd_cfg(2, "R5 config write");
        for (int k = 0; k < 10; k++) push_e(2, 32'hC000_0000 + 32'(k));
        rd_cfg(2, "R5 wp wrapped");
        for (int k = 0; k < 10; k++) pop_e(2, "R5 pop across wrap");
        rd_cfg(2, "R5 rp wrapped");

        // R6 / R8: 128-word ring, equal pointers while full
        wr_cfg(3, 5, 2, 0);
        for (int k = 0; k < 32; k++) push_e(3, 32'(k << 8));
        rd_cfg(3, "R6 full with equal pointers");
        rd_stat(1, "R6 lower status full");
        push_e(3, 32'hFFFF_0000);
        rd_stat(0, "R8 overflow flag");
        rd_cfg(3, "R8 pointers unchanged");
        pop_e(3, "R8 first entry intact");
        rd_cfg(3, "R6 full cleared after pop");

        // R7 / R9: underflow and sticky clear
        pop_w(0, 0, "R7 empty read zero");
        rd_stat(0, "R7 underflow flag");
        wr_stat0(32'hFFFF_FFFF);
        rd_stat(0, "R9 write ones keeps flags");
        wr_stat0(32'hFFFF_FFFE);
        rd_stat(0, "R9 clear underflow only");
        wr_stat0(32'h0000_0000);
        rd_stat(0, "R9 clear all");

        // R10: thresholds on queue 0 (16 entries)
        rd_stat(1, "R10 count 0");
        push_e(0, 32'h1);
        rd_stat(1, "R10 count 1");
        push_e(0, 32'h2);
        rd_stat(1, "R10 count 2");
        for (int k = 0; k < 13; k++) push_e(0, 32'h10 + 32'(k));
        rd_stat(1, "R10 count 15");
        push_e(0, 32'h3);
        rd_stat(1, "R10 count 16");
        for (int k = 0; k < 16; k++) pop_e(0, "R10 drain");

        // R11: upper group
        wr_cfg(5, 1, 0, 0);
        rd_stat(2, "R11 upper nearly-empty");
        push_e(5, 32'h5555_0001);
        push_e(5, 32'h5555_0002);
        push_e(5, 32'h5555_0003);
        rd_stat(3, "R11 upper full");
        rd_stat(2, "R11 upper nearly-empty after fill");
        rd_stat(0, "R11 no flag on upper overflow");
        pop_e(5, "R11 upper pop");
        pop_e(5, "R11 upper pop");
        pop_w(5, 0, "R11 upper empty read zero");
        rd_stat(0, "R11 no flag on upper underflow");
        rd_stat(3, "R11 upper not full");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule